// File: doc/BRIEF.md
# Management Controller Suspend Gate

This block decides whether an on-chip management controller runs or is held suspended. After a power-on or hard-reset event the controller always runs its initialization sequence. When initialization finishes, a non-volatile suspend-enable bit, which only the programmed configuration can set, is sampled once. If it is set, the controller is parked in a held state. If it is clear, the controller stays in normal operation until the next power-on event.

While the controller is held, the block cuts the JTAG signals that lead to it, refuses programming over the JTAG and SPI-slave ports, and answers service requests with a one-cycle denial strobe. An external test-reset pin can lift the hold for as long as it stays high. While the hold is lifted, JTAG and SPI-slave programming go through and every output of the init-status monitor is forced to zero. SPI-master auto-update does not depend on the mode. It only needs a boot-time trigger and its enable bit.

The programming engine, the TAP, the SPI protocol logic and the flash cell lie outside the block. They appear only as request, grant and plain data signals.

Top module: `mgmt_suspend_ctrl`

## Requirements
- R1: The mode output has four codes: 00 = initializing, 01 = running, 10 = held, 11 = lifted. While `rst_n` is low the mode is 00. A `por_evt` high at a clock edge makes the mode 00 after that edge, whatever the current mode and the suspend-enable bit.
- R2: In mode 00, `init_done` high at an edge moves the mode to 10 if `nv_susp_en` is 1, and to 01 otherwise. Changing `nv_susp_en` at any other time has no effect on the mode.
- R3: In mode 10, `jtag_to_ctrl` is all zeros. In every other mode it equals `jtag_in`.
- R4: `trst_pin` passes through two synchronizing flops. In mode 10, a pin that is high before edge N gives mode 11 after edge N+2. In mode 11, a pin that is low before edge N gives mode 10 after edge N+2. The pin has no effect in modes 00 and 01.
- R5: `pgm_gnt_jtag` and `pgm_gnt_spis` are high for the cycle after an edge at which the matching request was high and the mode was 01 or 11. Otherwise they are low.
- R6: `au_gnt` is high for the cycle after an edge at which `au_req`, `au_boot_trig` and `nv_au_en` were all high, in any mode. Otherwise it is low.
- R7: In mode 11, `mon_out` is all zeros. In every other mode it equals `mon_in`.
- R8: A `svc_req` high at an edge is answered in the next cycle. The answer is `svc_gnt` if the mode was 01 and `svc_deny` in any other mode. The two are never high together.
- R9: The release of `rst_n` is synchronized. The block leaves its reset values on the second rising edge after `rst_n` goes high. All registered outputs are 0 while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_evt | input | 1 | Power-on / hard-reset event, restarts initialization |
| init_done | input | 1 | Initialization sequence finished |
| nv_suspend_en | input | 1 | Non-volatile suspend-enable bit from configuration |
| nv_au_en | input | 1 | Non-volatile auto-update enable bit |
| trst_pin | input | 1 | Asynchronous external test-reset pin |
| jtag_in | input | JTAG_W | JTAG signals from the pins |
| jtag_to_ctrl | output | JTAG_W | JTAG signals passed to the controller |
| pgm_req_jtag | input | 1 | Programming request over JTAG |
| pgm_req_spis | input | 1 | Programming request over SPI slave |
| pgm_gnt_jtag | output | 1 | JTAG programming grant |
| pgm_gnt_spis | output | 1 | SPI-slave programming grant |
| au_req | input | 1 | SPI-master auto-update request |
| au_boot_trig | input | 1 | Request came from power-up or the device reset pin |
| au_gnt | output | 1 | Auto-update grant |
| svc_req | input | 1 | System service request |
| svc_gnt | output | 1 | Service accepted strobe |
| svc_deny | output | 1 | Service refused strobe |
| mon_in | input | MON_W | Init-status monitor outputs before forcing |
| mon_out | output | MON_W | Init-status monitor outputs after forcing |
| state_o | output | 2 | Current mode code |

## Verification
A wrong mode shows up in the same cycle on `state_o`. It also shows up at once on the combinational paths: held mode zeroes `jtag_to_ctrl`, and lifted mode zeroes `mon_out`. One cycle later it appears on the registered grant and deny strobes. A synchronizer with the wrong depth moves the held/lifted change by a cycle, and the per-clock comparison catches this on the edge where it happens. The bench drives the pin in every mode, toggles the suspend-enable bit after initialization, and issues requests in every mode, so that gating errors cannot hide.

// File: rtl/susp_pkg.sv
package susp_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'b00,
    ST_RUN  = 2'b01,
    ST_HELD = 2'b10,
    ST_LIFT = 2'b11
  } mode_e;
endpackage

// File: rtl/susp_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module susp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/susp_bit_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
module susp_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b0;
          else        stg_q[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b0;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/susp_fsm.sv
// Mode state machine: init, run, held, lifted.
module susp_fsm
  import susp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  por_evt,
  input  logic  init_done,
  input  logic  nv_suspend_en,
  input  logic  lift,
  output mode_e mode
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (por_evt) begin
      mode_d = ST_INIT;
    end else begin
      unique case (mode_q)
        ST_INIT: if (init_done) mode_d = nv_suspend_en ? ST_HELD : ST_RUN;
        ST_RUN:  mode_d = ST_RUN;
        ST_HELD: if (lift)      mode_d = ST_LIFT;
        ST_LIFT: if (!lift)     mode_d = ST_HELD;
        default: mode_d = ST_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= ST_INIT;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/susp_gate.sv
// Input blocking, programming permission, service answers, monitor forcing.
module susp_gate
  import susp_pkg::*;
#(
  parameter int JW = 3,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic [JW-1:0] jtag_in,
  output logic [JW-1:0] jtag_to_ctrl,
  input  logic [MW-1:0] mon_in,
  output logic [MW-1:0] mon_out,
  input  logic          pgm_req_jtag,
  input  logic          pgm_req_spis,
  output logic          pgm_gnt_jtag,
  output logic          pgm_gnt_spis,
  input  logic          au_req,
  input  logic          au_boot_trig,
  input  logic          nv_au_en,
  output logic          au_gnt,
  input  logic          svc_req,
  output logic          svc_gnt,
  output logic          svc_deny
);
  logic held, lifted, running, prog_ok;
  logic gj_d, gs_d, au_d, sg_d, sd_d;
  logic gj_q, gs_q, au_q, sg_q, sd_q;

  assign held    = (mode == ST_HELD);
  assign lifted  = (mode == ST_LIFT);
  assign running = (mode == ST_RUN);
  assign prog_ok = running | lifted;

  assign jtag_to_ctrl = held   ? '0 : jtag_in;
  assign mon_out      = lifted ? '0 : mon_in;

  always_comb begin
    gj_d = pgm_req_jtag & prog_ok;
    gs_d = pgm_req_spis & prog_ok;
    au_d = au_req & au_boot_trig & nv_au_en;
    sg_d = svc_req & running;
    sd_d = svc_req & ~running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gj_q <= 1'b0;
      gs_q <= 1'b0;
      au_q <= 1'b0;
      sg_q <= 1'b0;
      sd_q <= 1'b0;
    end else begin
      gj_q <= gj_d;
      gs_q <= gs_d;
      au_q <= au_d;
      sg_q <= sg_d;
      sd_q <= sd_d;
    end
  end

  assign pgm_gnt_jtag = gj_q;
  assign pgm_gnt_spis = gs_q;
  assign au_gnt       = au_q;
  assign svc_gnt      = sg_q;
  assign svc_deny     = sd_q;
endmodule

// File: rtl/mgmt_suspend_ctrl.sv
module mgmt_suspend_ctrl
  import susp_pkg::*;
#(
  parameter int JTAG_W      = 3,
  parameter int MON_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              init_done,
  input  logic              nv_suspend_en,
  input  logic              nv_au_en,
  input  logic              trst_pin,
  input  logic [JTAG_W-1:0] jtag_in,
  output logic [JTAG_W-1:0] jtag_to_ctrl,
  input  logic              pgm_req_jtag,
  input  logic              pgm_req_spis,
  output logic              pgm_gnt_jtag,
  output logic              pgm_gnt_spis,
  input  logic              au_req,
  input  logic              au_boot_trig,
  output logic              au_gnt,
  input  logic              svc_req,
  output logic              svc_gnt,
  output logic              svc_deny,
  input  logic [MON_W-1:0]  mon_in,
  output logic [MON_W-1:0]  mon_out,
  output logic [1:0]        state_o
);
  logic  rst_sync_n;
  logic  lift_s;
  mode_e mode;

  susp_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  susp_bit_sync #(.STAGES(SYNC_STAGES)) i_trst_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (trst_pin),
    .q     (lift_s)
  );

  susp_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .por_evt       (por_evt),
    .init_done     (init_done),
    .nv_suspend_en (nv_suspend_en),
    .lift          (lift_s),
    .mode          (mode)
  );

  susp_gate #(.JW(JTAG_W), .MW(MON_W)) i_gate (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode         (mode),
    .jtag_in      (jtag_in),
    .jtag_to_ctrl (jtag_to_ctrl),
    .mon_in       (mon_in),
    .mon_out      (mon_out),
    .pgm_req_jtag (pgm_req_jtag),
    .pgm_req_spis (pgm_req_spis),
    .pgm_gnt_jtag (pgm_gnt_jtag),
    .pgm_gnt_spis (pgm_gnt_spis),
    .au_req       (au_req),
    .au_boot_trig (au_boot_trig),
    .nv_au_en     (nv_au_en),
    .au_gnt       (au_gnt),
    .svc_req      (svc_req),
    .svc_gnt      (svc_gnt),
    .svc_deny     (svc_deny)
  );

  assign state_o = mode;
endmodule

// File: rtl/susp_ctrl_chk.sv
module susp_ctrl_chk #(
  parameter int JW = 3,
  parameter int MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_evt,
  input logic          init_done,
  input logic          nv_suspend_en,
  input logic [JW-1:0] jtag_to_ctrl,
  input logic [MW-1:0] mon_out,
  input logic          pgm_gnt_jtag,
  input logic          pgm_gnt_spis,
  input logic          svc_gnt,
  input logic          svc_deny,
  input logic [1:0]    state_o
);
  // R1
  por_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> state_o == 2'b00);

  // R2
  held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && init_done && nv_suspend_en && !por_evt) |=> state_o == 2'b10);

  // R3
  held_blocks_jtag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b10 |-> jtag_to_ctrl == '0);

  // R4
  lift_from_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11 && $past(state_o) != 2'b11) |-> $past(state_o) == 2'b10);

  // R5
  pgm_jtag_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_gnt_jtag |-> ($past(state_o) == 2'b01 || $past(state_o) == 2'b11));

  // R5
  pgm_spis_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_gnt_spis |-> ($past(state_o) == 2'b01 || $past(state_o) == 2'b11));

  // R7
  lifted_mon_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b11 |-> mon_out == '0);

  // R8
  svc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_gnt && svc_deny));
endmodule

bind mgmt_suspend_ctrl susp_ctrl_chk #(.JW(JTAG_W), .MW(MON_W)) i_susp_ctrl_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .por_evt       (por_evt),
  .init_done     (init_done),
  .nv_suspend_en (nv_suspend_en),
  .jtag_to_ctrl  (jtag_to_ctrl),
  .mon_out       (mon_out),
  .pgm_gnt_jtag  (pgm_gnt_jtag),
  .pgm_gnt_spis  (pgm_gnt_spis),
  .svc_gnt       (svc_gnt),
  .svc_deny      (svc_deny),
  .state_o       (state_o)
);

// File: tb/test_mgmt_suspend_ctrl.sv
module test_mgmt_suspend_ctrl;
  localparam int JW = 3;
  localparam int MW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic por_evt = 0, init_done = 0, nv_suspend_en = 0, nv_au_en = 0, trst_pin = 0;
  logic [JW-1:0] jtag_in = '0;
  logic pgm_req_jtag = 0, pgm_req_spis = 0, au_req = 0, au_boot_trig = 0, svc_req = 0;
  logic [MW-1:0] mon_in = '0;
  logic [JW-1:0] jtag_to_ctrl;
  logic [MW-1:0] mon_out;
  logic pgm_gnt_jtag, pgm_gnt_spis, au_gnt, svc_gnt, svc_deny;
  logic [1:0] state_o;

  mgmt_suspend_ctrl i_mgmt_suspend_ctrl (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .init_done(init_done),
    .nv_suspend_en(nv_suspend_en), .nv_au_en(nv_au_en), .trst_pin(trst_pin),
    .jtag_in(jtag_in), .jtag_to_ctrl(jtag_to_ctrl),
    .pgm_req_jtag(pgm_req_jtag), .pgm_req_spis(pgm_req_spis),
    .pgm_gnt_jtag(pgm_gnt_jtag), .pgm_gnt_spis(pgm_gnt_spis),
    .au_req(au_req), .au_boot_trig(au_boot_trig), .au_gnt(au_gnt),
    .svc_req(svc_req), .svc_gnt(svc_gnt), .svc_deny(svc_deny),
    .mon_in(mon_in), .mon_out(mon_out), .state_o(state_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural reference model, written from the requirements
  bit m_r1 = 0, m_r2 = 0, m_s1 = 0, m_s2 = 0;
  int m_st = 0;
  bit m_gj = 0, m_gs = 0, m_au = 0, m_sg = 0, m_sd = 0;

  always @(posedge clk or negedge rst_n) begin
    int nst;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_s1 = 0; m_s2 = 0; m_st = 0;
      m_gj = 0; m_gs = 0; m_au = 0; m_sg = 0; m_sd = 0;
    end else begin
      if (m_r2) begin
        m_gj = pgm_req_jtag && (m_st == 1 || m_st == 3);
        m_gs = pgm_req_spis && (m_st == 1 || m_st == 3);
        m_au = au_req && au_boot_trig && nv_au_en;
        m_sg = svc_req && (m_st == 1);
        m_sd = svc_req && (m_st != 1);
        nst = m_st;
        if (por_evt) nst = 0;
        else if (m_st == 0 && init_done) nst = nv_suspend_en ? 2 : 1;
        else if (m_st == 2 && m_s2) nst = 3;
        else if (m_st == 3 && !m_s2) nst = 2;
        m_st = nst;
        m_s2 = m_s1;
        m_s1 = trst_pin;
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
  end

  task automatic cmp(input string req, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [JW-1:0] ej;
    logic [MW-1:0] em;
    ej = (m_st == 2) ? '0 : jtag_in;
    em = (m_st == 3) ? '0 : mon_in;
    cmp("R1/R2/R4/R9", "state_o", 32'(state_o), 32'(m_st));
    cmp("R3", "jtag_to_ctrl", 32'(jtag_to_ctrl), 32'(ej));
    cmp("R7", "mon_out", 32'(mon_out), 32'(em));
    cmp("R5", "pgm_gnt_jtag", 32'(pgm_gnt_jtag), 32'(m_gj));
    cmp("R5", "pgm_gnt_spis", 32'(pgm_gnt_spis), 32'(m_gs));
    cmp("R6", "au_gnt", 32'(au_gnt), 32'(m_au));
    cmp("R8", "svc_gnt", 32'(svc_gnt), 32'(m_sg));
    cmp("R8", "svc_deny", 32'(svc_deny), 32'(m_sd));
  endtask

  // Inputs are set right after a falling edge; outputs are compared 1 ns later.
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      #1 check_all();
      @(negedge clk);
    end
  endtask

  task automatic all_req(input logic v);
    pgm_req_jtag = v; pgm_req_spis = v; svc_req = v;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9: reset values, then synchronized release
    cyc(3);
    rst_n = 1;
    jtag_in = 3'b101; mon_in = 2'b11;
    cyc(4);
    // R2: suspend disabled -> running
    init_done = 1; cyc(); init_done = 0; cyc();
    // R5/R8: grants while running
    all_req(1); cyc(); all_req(0); cyc();
    // R4: pin ignored while running
    trst_pin = 1; cyc(5); trst_pin = 0; cyc(3);
    // R6: auto-update combinations
    au_req = 1; au_boot_trig = 1; nv_au_en = 1; cyc();
    au_boot_trig = 0; cyc();
    au_boot_trig = 1; nv_au_en = 0; cyc();
    au_req = 0; au_boot_trig = 0; cyc();
    // R2: bit change after init has no effect
    nv_suspend_en = 1; cyc(3);
    // R1: restart; R4: pin ignored during init
    por_evt = 1; cyc(); por_evt = 0;
    trst_pin = 1; cyc(3); trst_pin = 0; cyc(3);
    init_done = 1; cyc(); init_done = 0; cyc();
    // R3/R5/R8/R6 in held mode
    jtag_in = 3'b111; all_req(1); au_req = 1; au_boot_trig = 1; nv_au_en = 1; cyc();
    all_req(0); au_req = 0; cyc();
    nv_suspend_en = 0; cyc(3);
    // R4/R7: lift, requests while lifted, drop
    trst_pin = 1; cyc(4);
    all_req(1); cyc(); all_req(0); cyc();
    trst_pin = 0; cyc(4);
    // R1: restart from held
    por_evt = 1; cyc(); por_evt = 0; cyc(2);
    // R9: reset in the middle of operation
    rst_n = 0; cyc(2); rst_n = 1; cyc(3);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      por_evt       = ($urandom_range(0, 199) == 0);
      init_done     = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) trst_pin = ~trst_pin;
      if ($urandom_range(0, 49) == 0) nv_suspend_en = ~nv_suspend_en;
      nv_au_en      = 1'($urandom);
      jtag_in       = JW'($urandom);
      mon_in        = MW'($urandom);
      pgm_req_jtag  = 1'($urandom);
      pgm_req_spis  = 1'($urandom);
      au_req        = 1'($urandom);
      au_boot_trig  = 1'($urandom);
      svc_req       = 1'($urandom);
      cyc();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule